// File: doc/BRIEF.md
# Microphone capture receive buffer with DMA request

This block sits between a decimated microphone capture stream and a DMA engine. Each incoming 32-bit sample is stored in a first-in first-out buffer while capture is running. A bus master drains the buffer by reading one fixed data offset. A DMA request line is raised while the buffer holds at least a programmed number of words, so the DMA engine can move fixed-size bursts without polling.

Software uses a small register bus to control the block. One register starts and stops capture. The same register carries a write-one flush that clears the buffer and then clears itself. A second register enables requests and sets the threshold, written as the word count minus one. A status register reports a sticky overflow flag and the current request level. Two plain configuration words and a read-only version word complete the map. Read data is combinational: it is valid in the same cycle as the read strobe, and a read of the data offset removes one word at the next clock edge.

Top module: `mic_rx_dma_path`

## Requirements
- R1: After reset, capture is stopped, DMA requests are disabled with a threshold field of 0, the buffer is empty, `dma_req` is low, and the system (0x00), DMA (0x18), status (0x24) and data (0x30) offsets all read 0.
- R2: A sample presented with `smp_valid` is stored only while the run bit (bit 2 of offset 0x00) is 1. Successive reads of offset 0x30 return the stored words in arrival order, and the run bit reads back as written.
- R3: A sample that arrives when the buffer holds DEPTH words is dropped and sets status bit 0 (offset 0x24). That bit stays set until software writes 1 to it, and the words already stored are unchanged.
- R4: A read of offset 0x30 while the buffer is empty returns 0 and leaves the read position where it was, so the next stored sample is the next one returned.
- R5: Writing 1 to bit 0 of offset 0x00 empties the buffer within two clock cycles. The bit then reads 0, and bit 2 of the same write sets the run state.
- R6: `dma_req` is high exactly when DMA control bit 8 (offset 0x18) is 1 and the buffer level is at least the value in bits 6:0 plus one. A field value of 15 gives a request at 16 words. The request drops as soon as the level falls below that value or the enable is cleared.
- R7: Status bit 1 (offset 0x24) reads the current value of `dma_req`.
- R8: Offset 0x58 returns the VERSION parameter, and writes to it have no effect.
- R9: Offsets 0x04 and 0x0C are 32-bit configuration words that read back the last value written.
- R10: The stop sequence drops `dma_req` and empties the buffer, and no later sample is stored. The sequence is a write clearing DMA bit 8, followed by one write to offset 0x00 with the run bit at 0 and the flush bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Capture sample strobe |
| smp_data | input | 32 | Capture sample word |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid while bus_rd is high |
| dma_req | output | 1 | DMA request level |

## Verification
The bench places the request threshold at the edge: 15 words give no request, the 16th raises it, and a single read drops it. An off-by-one in the minus-one encoding would move that edge by one word. It fills the buffer past DEPTH. A design that wraps instead of dropping would lose the first word or corrupt the order, and one whose overflow flag is not sticky would lose the flag before it is read. The bench reads the empty buffer and then stores one word. A design that advances the read position on an empty read would return stale data instead of that word. It also checks that a flush empties the buffer and that the stop sequence leaves no request pending.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    localparam logic [7:0] OFS_SYS  = 8'h00;
    localparam logic [7:0] OFS_CTL0 = 8'h04;
    localparam logic [7:0] OFS_CLK  = 8'h0C;
    localparam logic [7:0] OFS_DMA  = 8'h18;
    localparam logic [7:0] OFS_STAT = 8'h24;
    localparam logic [7:0] OFS_RXD  = 8'h30;
    localparam logic [7:0] OFS_VER  = 8'h58;

    localparam int SYS_RUN_BIT   = 2;
    localparam int SYS_FLUSH_BIT = 0;
    localparam int DMA_EN_BIT    = 8;
    localparam int THR_W         = 7;

    typedef struct packed {
        logic             run;
        logic             flush;
        logic             dma_en;
        logic [THR_W-1:0] thr_m1;
        logic [31:0]      ctl0;
        logic [31:0]      clkc;
        logic             ovf;
    } ctl_state_t;

endpackage

// File: rtl/mrx_fifo.sv
module mrx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                wdata,
    input  logic                         pop,
    input  logic                         flush,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty,
    output logic                         drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [LW-1:0] lvl;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full  = (s_q.lvl == LW'(DEPTH));
    assign empty = (s_q.lvl == '0);
    assign level = s_q.lvl;
    assign head  = mem_q[s_q.rd];
    assign drop  = push && full && !flush;

    always_comb begin
        s_d     = s_q;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_push)
                s_d.wr = (s_q.wr == AW'(DEPTH - 1)) ? '0 : s_q.wr + AW'(1);
            if (do_pop)
                s_d.rd = (s_q.rd == AW'(DEPTH - 1)) ? '0 : s_q.rd + AW'(1);
            case ({do_push, do_pop})
                2'b10:   s_d.lvl = s_q.lvl + LW'(1);
                2'b01:   s_d.lvl = s_q.lvl - LW'(1);
                default: s_d.lvl = s_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wr] <= wdata;
    end

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lvl <= LW'(DEPTH));

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (s_q.lvl == $past(s_q.lvl)));

    assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_q.lvl == '0));

endmodule

// File: rtl/mrx_regs.sv
module mrx_regs
    import mrx_pkg::*;
#(
    parameter int          LW      = 6,
    parameter logic [31:0] VERSION = 32'h0001_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [LW-1:0] level,
    input  logic          empty,
    input  logic [31:0]   head,
    input  logic          drop,
    output logic          run,
    output logic          flush,
    output logic          pop,
    output logic          dma_req
);
    localparam int CW = ((LW > THR_W) ? LW : THR_W) + 1;

    ctl_state_t s_d, s_q;
    logic [CW-1:0] lvl_x, thr_x;
    logic [31:0] rd_mux;

    assign lvl_x   = CW'(level);
    assign thr_x   = CW'(s_q.thr_m1) + CW'(1);
    assign dma_req = s_q.dma_en && (lvl_x >= thr_x);
    assign run     = s_q.run;
    assign flush   = s_q.flush;
    assign pop     = bus_rd && (bus_addr == OFS_RXD) && !empty;

    always_comb begin
        s_d       = s_q;
        s_d.flush = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                OFS_SYS: begin
                    s_d.run   = bus_wdata[SYS_RUN_BIT];
                    s_d.flush = bus_wdata[SYS_FLUSH_BIT];
                end
                OFS_CTL0: s_d.ctl0 = bus_wdata;
                OFS_CLK:  s_d.clkc = bus_wdata;
                OFS_DMA: begin
                    s_d.dma_en = bus_wdata[DMA_EN_BIT];
                    s_d.thr_m1 = bus_wdata[THR_W-1:0];
                end
                OFS_STAT: if (bus_wdata[0]) s_d.ovf = 1'b0;
                default: ;
            endcase
        end
        if (drop) s_d.ovf = 1'b1;
    end

    always_comb begin
        case (bus_addr)
            OFS_SYS:  rd_mux = {29'b0, s_q.run, 1'b0, s_q.flush};
            OFS_CTL0: rd_mux = s_q.ctl0;
            OFS_CLK:  rd_mux = s_q.clkc;
            OFS_DMA:  rd_mux = {23'b0, s_q.dma_en, 1'b0, s_q.thr_m1};
            OFS_STAT: rd_mux = {30'b0, dma_req, s_q.ovf};
            OFS_RXD:  rd_mux = empty ? 32'h0 : head;
            OFS_VER:  rd_mux = VERSION;
            default:  rd_mux = 32'h0;
        endcase
        bus_rdata = bus_rd ? rd_mux : 32'h0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_flush_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flush && !(bus_wr && bus_addr == OFS_SYS && bus_wdata[SYS_FLUSH_BIT]))
        |=> !s_q.flush);

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovf && !(bus_wr && bus_addr == OFS_STAT && bus_wdata[0])) |=> s_q.ovf);

endmodule

// File: rtl/mic_rx_dma_path.sv
module mic_rx_dma_path #(
    parameter int          DEPTH   = 32,
    parameter logic [31:0] VERSION = 32'h0001_0203
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_valid,
    input  logic [31:0] smp_data,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        dma_req
);
    localparam int LW = $clog2(DEPTH + 1);

    logic          run, flush, pop, push, full, empty, drop;
    logic [LW-1:0] level;
    logic [31:0]   head;

    assign push = smp_valid && run;

    mrx_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (smp_data),
        .pop   (pop),
        .flush (flush),
        .head  (head),
        .level (level),
        .full  (full),
        .empty (empty),
        .drop  (drop)
    );

    mrx_regs #(.LW(LW), .VERSION(VERSION)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .level     (level),
        .empty     (empty),
        .head      (head),
        .drop      (drop),
        .run       (run),
        .flush     (flush),
        .pop       (pop),
        .dma_req   (dma_req)
    );

    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == mrx_pkg::OFS_RXD && level == '0 && !push) |=> (level == '0));

    assert_full_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !empty);

endmodule

// File: tb/mic_rx_dma_path_test.sv
module mic_rx_dma_path_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;
    localparam logic [31:0] VER = 32'h0001_0203;
    localparam int WATCHDOG = 20000;

    logic clk = 0, rst_n = 0;
    logic smp_valid = 0;
    logic [31:0] smp_data = 0;
    logic [7:0] bus_addr = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic dma_req;

    int checks = 0, errors = 0;
    bit done = 0;
    bit mrun = 0;
    logic [31:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mic_rx_dma_path #(.DEPTH(DEPTH), .VERSION(VER)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_req(dma_req));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
        if (a == 8'h00) begin
            mrun = d[2];
            if (d[0]) exp_q.delete();
        end
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic push_sample(input logic [31:0] d);
        @(negedge clk);
        smp_valid = 1; smp_data = d;
        @(negedge clk);
        smp_valid = 0;
        if (mrun && exp_q.size() < DEPTH) exp_q.push_back(d);
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string req);
        logic [31:0] v;
        bus_read(a, v);
        check(v === e, req, v, e);
    endtask

    task automatic monitor_read(input string req);
        logic [31:0] v, e;
        bus_read(8'h30, v);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'h0;
        check(v === e, req, v, e);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check(dma_req === 1'b0, "R1 dma_req", {31'b0, dma_req}, 0);
        expect_reg(8'h00, 0, "R1 sys");
        expect_reg(8'h18, 0, "R1 dma");
        expect_reg(8'h24, 0, "R1 status");
        monitor_read("R1 data empty");

        // R8 version read-only
        expect_reg(8'h58, VER, "R8 version");
        bus_write(8'h58, 32'hFFFF_FFFF);
        expect_reg(8'h58, VER, "R8 version after write");

        // R9 configuration words
        bus_write(8'h04, 32'hA5A5_1234);
        bus_write(8'h0C, 32'h0000_0029);
        expect_reg(8'h04, 32'hA5A5_1234, "R9 ctl0");
        expect_reg(8'h0C, 32'h0000_0029, "R9 clkc");

        // R2 samples ignored while stopped
        for (int i = 0; i < 3; i++) push_sample(32'hDEAD_0000 + i);
        monitor_read("R2 stopped ignores");

        // R2 run and order
        bus_write(8'h00, 32'h4);
        expect_reg(8'h00, 32'h4, "R2 run readback");
        for (int i = 0; i < 5; i++) push_sample(32'h1000_0000 + 32'(i * 7));
        for (int i = 0; i < 5; i++) monitor_read("R2 order");

        // R4 empty read leaves pointer
        monitor_read("R4 empty read zero");
        push_sample(32'hCAFE_0001);
        monitor_read("R4 next word after empty read");

        // R6/R7 threshold 16 (field 15)
        bus_write(8'h18, (32'h1 << 8) | 32'd15);
        for (int i = 0; i < 15; i++) push_sample(32'h2000_0000 + i);
        check(dma_req === 1'b0, "R6 no req at 15", {31'b0, dma_req}, 0);
        expect_reg(8'h24, 32'h0, "R7 status bit1 low");
        push_sample(32'h2000_000F);
        check(dma_req === 1'b1, "R6 req at 16", {31'b0, dma_req}, 1);
        expect_reg(8'h24, 32'h2, "R7 status bit1 high");
        monitor_read("R6 drain one");
        check(dma_req === 1'b0, "R6 drop below", {31'b0, dma_req}, 0);
        push_sample(32'h2000_0010);
        check(dma_req === 1'b1, "R6 req again", {31'b0, dma_req}, 1);
        bus_write(8'h18, 32'd15);
        check(dma_req === 1'b0, "R6 enable cleared", {31'b0, dma_req}, 0);
        while (exp_q.size() > 0) monitor_read("R2 drain order");

        // R3 overflow
        for (int i = 0; i < DEPTH + 1; i++) push_sample(32'h3000_0000 + i);
        expect_reg(8'h24, 32'h1, "R3 overflow set");
        expect_reg(8'h24, 32'h1, "R3 overflow sticky");
        for (int i = 0; i < DEPTH; i++) monitor_read("R3 stored words intact");
        monitor_read("R3 dropped word absent");
        expect_reg(8'h24, 32'h1, "R3 sticky after drain");
        bus_write(8'h24, 32'h1);
        expect_reg(8'h24, 32'h0, "R3 cleared by write one");

        // R5 flush
        for (int i = 0; i < 4; i++) push_sample(32'h4000_0000 + i);
        bus_write(8'h00, 32'h5);
        expect_reg(8'h00, 32'h4, "R5 flush bit self clears");
        monitor_read("R5 buffer empty after flush");
        push_sample(32'h4444_5555);
        monitor_read("R5 works after flush");

        // R10 stop sequence
        bus_write(8'h18, (32'h1 << 8) | 32'd0);
        push_sample(32'h5000_0001);
        push_sample(32'h5000_0002);
        check(dma_req === 1'b1, "R10 req before stop", {31'b0, dma_req}, 1);
        bus_write(8'h18, 32'h0);
        bus_write(8'h00, 32'h1);
        check(dma_req === 1'b0, "R10 req after stop", {31'b0, dma_req}, 0);
        expect_reg(8'h00, 32'h0, "R10 sys after stop");
        push_sample(32'h5000_0003);
        monitor_read("R10 no sample after stop");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule